// File: doc/BRIEF.md
# Shared Memory Host Access Arbiter

This block lets a 32-bit host bus reach a memory of 36-bit words that a processing element (PE) also uses. The host asks for one word at a time. It sets a direction, a word mode and an access style with each request. In narrow mode a word crosses the host bus as one beat, and only its low 32 bits move. In wide mode a word crosses as two beats: bits 31:0 go first, then bits 35:32 in the low nibble of the second beat.

There are two access styles. A preemptive access first asks the PE's user clock to stop. It touches the memory only after that stop is acknowledged, so the PE never sees the access. A non-preemptive access leaves the clock running. It takes the memory port away from the PE for the length of the transfer, and it raises a busy flag on the PE side so the PE holds its requests. A PE access presented in the cycle the host request is accepted still reaches memory. An access already under way from the PE is therefore never lost. A mode input chooses between flow-through memory timing (read data one cycle after the read strobe) and pipelined timing (two cycles).

Top module: `hostMemPort`

## Requirements
- R1: After reset, peBusy, clkStopReq, hostRvalid, hostDone and memEn are all low.
- R2: A narrow write (hostWide=0) takes one hostBeat. In that same cycle it writes {4'b0, hostWdata} to the address latched at acceptance.
- R3: A wide write (hostWide=1) takes two hostBeat cycles, which need not be adjacent. The first beat supplies word bits 31:0 and the second beat's bits 3:0 supply word bits 35:32. The memory is written only in the cycle of the second beat.
- R4: A narrow read returns one hostRvalid beat carrying word bits 31:0.
- R5: A wide read returns two hostRvalid beats in adjacent cycles: bits 31:0 first, then {28'b0, bits 35:32}.
- R6: A read strobe (memEn=1, memWe=0) is followed by 1 idle cycle (pipeMode=0) or 2 idle cycles (pipeMode=1). The first beat is valid in the next cycle.
- R7: For a preemptive request, clkStopReq rises the cycle after acceptance. The memory is not driven until a cycle after clkStopAck has been seen high. clkStopReq stays high through the last beat and is low in the hostDone cycle.
- R8: A non-preemptive request never raises clkStopReq. The host owns the port from the cycle after acceptance.
- R9: A PE request presented in the cycle a host request is accepted is still forwarded to memory.
- R10: peBusy is high from the cycle after acceptance through the hostDone cycle. While it is high, PE requests do not reach memory.
- R11: hostDone is a one-cycle pulse after the last beat of a transfer. In the following cycle peBusy is low and PE requests pass to memory again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pipeMode | input | 1 | 1 = pipelined memory (2-cycle read), 0 = flow-through (1-cycle) |
| hostReq | input | 1 | Host request, sampled when idle |
| hostWe | input | 1 | Request is a write |
| hostWide | input | 1 | 1 = two-beat 36-bit word, 0 = one-beat low 32 bits |
| hostPreempt | input | 1 | 1 = stop the user clock for the access |
| hostAddr | input | ADDR_W | Word address, latched at acceptance |
| hostBeat | input | 1 | Write data beat valid |
| hostWdata | input | 32 | Write data beat |
| hostRvalid | output | 1 | Read data beat valid |
| hostRdata | output | 32 | Read data beat |
| hostDone | output | 1 | Transfer finished pulse |
| peReq | input | 1 | PE memory request |
| peWe | input | 1 | PE write |
| peAddr | input | ADDR_W | PE address |
| peWdata | input | 36 | PE write word |
| peRdata | output | 36 | Read word returned to the PE |
| peBusy | output | 1 | Host owns memory; PE must hold its request |
| clkStopReq | output | 1 | Request to stop the user clock |
| clkStopAck | input | 1 | User clock is stopped |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | 36 | Memory write word |
| memRdata | input | 36 | Memory read word |

## Verification
The bench hits the seam between the two beats of a wide write. It leaves an idle gap between them and watches that nothing is written early, because a design that wrote on the first beat would store a word whose high nibble is stale. It reads words whose high nibble is set, in both narrow and wide modes and under both memory timings. An off-by-one in the latency wait would return the previous word or garbage, and a narrow write that failed to clear the top nibble would show up on a later wide read. It presents a PE write in the very acceptance cycle and PE requests throughout a delayed clock-stop handshake. A design that dropped the in-flight PE write, or let the PE through while busy, would corrupt memory contents the later reads expose.

// File: rtl/hmpPkg.sv
package hmpPkg;
  localparam int BUS_W  = 32;
  localparam int WORD_W = 36;
  localparam int HI_W   = WORD_W - BUS_W;

  typedef enum logic [2:0] {
    S_IDLE, S_STOPW, S_WBEAT, S_RISSUE, S_RWAIT, S_RLO, S_RHI, S_DONE
  } hmpState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic own;
    logic capLow;
    logic memWr;
    logic memRd;
    logic capRd;
    logic sendLo;
    logic sendHi;
  } hmpStrobe_t;
endpackage

// File: rtl/hmpCtrl.sv
module hmpCtrl
  import hmpPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pipeMode,
  input  logic       hostReq,
  input  logic       hostWe,
  input  logic       hostWide,
  input  logic       hostPreempt,
  input  logic       hostBeat,
  input  logic       clkStopAck,
  output hmpStrobe_t strb,
  output logic       wideLat,
  output logic       preLat,
  output logic       peBusy,
  output logic       clkStopReq,
  output logic       hostDone
);
  hmpState_e state, nextState;
  logic weLat, beatHi, waited;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      S_IDLE: if (hostReq) begin
        strb.accept = 1'b1;
        if (hostPreempt) nextState = S_STOPW;
        else             nextState = hostWe ? S_WBEAT : S_RISSUE;
      end
      S_STOPW: if (clkStopAck) nextState = weLat ? S_WBEAT : S_RISSUE;
      S_WBEAT: begin
        strb.own = 1'b1;
        if (hostBeat) begin
          if (!wideLat || beatHi) begin
            strb.memWr = 1'b1;
            nextState  = S_DONE;
          end else begin
            strb.capLow = 1'b1;
          end
        end
      end
      S_RISSUE: begin
        strb.own   = 1'b1;
        strb.memRd = 1'b1;
        nextState  = S_RWAIT;
      end
      S_RWAIT: begin
        strb.own = 1'b1;
        if (!pipeMode || waited) begin
          strb.capRd = 1'b1;
          nextState  = S_RLO;
        end
      end
      S_RLO: begin
        strb.own    = 1'b1;
        strb.sendLo = 1'b1;
        nextState   = wideLat ? S_RHI : S_DONE;
      end
      S_RHI: begin
        strb.own    = 1'b1;
        strb.sendHi = 1'b1;
        nextState   = S_DONE;
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      weLat   <= 1'b0;
      wideLat <= 1'b0;
      preLat  <= 1'b0;
      beatHi  <= 1'b0;
      waited  <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.accept) begin
        weLat   <= hostWe;
        wideLat <= hostWide;
        preLat  <= hostPreempt;
        beatHi  <= 1'b0;
        waited  <= 1'b0;
      end
      if (strb.capLow) beatHi <= 1'b1;
      if (state == S_RWAIT) waited <= 1'b1;
    end
  end

  assign peBusy     = (state != S_IDLE);
  assign hostDone   = (state == S_DONE);
  assign clkStopReq = preLat && (state != S_IDLE) && (state != S_DONE);
endmodule

// File: rtl/hmpData.sv
module hmpData
  import hmpPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  hmpStrobe_t        strb,
  input  logic              wideLat,
  input  logic              peBusy,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [BUS_W-1:0]  hostWdata,
  output logic              hostRvalid,
  output logic [BUS_W-1:0]  hostRdata,
  input  logic              peReq,
  input  logic              peWe,
  input  logic [ADDR_W-1:0] peAddr,
  input  logic [WORD_W-1:0] peWdata,
  output logic [WORD_W-1:0] peRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata
);
  logic [ADDR_W-1:0] addrLat;
  logic [BUS_W-1:0]  lowLat;
  logic [WORD_W-1:0] rdCap;
  logic [WORD_W-1:0] hostWord;
  logic              peGo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLat <= '0;
      lowLat  <= '0;
      rdCap   <= '0;
    end else begin
      if (strb.accept) addrLat <= hostAddr;
      if (strb.capLow) lowLat  <= hostWdata;
      if (strb.capRd)  rdCap   <= memRdata;
    end
  end

  assign hostWord = wideLat ? {hostWdata[HI_W-1:0], lowLat}
                            : {{HI_W{1'b0}}, hostWdata};
  assign peGo     = peReq && !peBusy;

  assign memEn    = strb.own ? (strb.memWr || strb.memRd) : peGo;
  assign memWe    = strb.own ? strb.memWr : (peGo && peWe);
  assign memAddr  = strb.own ? addrLat : peAddr;
  assign memWdata = strb.own ? hostWord : peWdata;
  assign peRdata  = memRdata;

  assign hostRvalid = strb.sendLo || strb.sendHi;
  assign hostRdata  = strb.sendHi ? {{(BUS_W-HI_W){1'b0}}, rdCap[WORD_W-1:BUS_W]}
                                  : rdCap[BUS_W-1:0];
endmodule

// File: rtl/hostMemPort.sv
module hostMemPort
  import hmpPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic              hostWide,
  input  logic              hostPreempt,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostBeat,
  input  logic [31:0]       hostWdata,
  output logic              hostRvalid,
  output logic [31:0]       hostRdata,
  output logic              hostDone,
  input  logic              peReq,
  input  logic              peWe,
  input  logic [ADDR_W-1:0] peAddr,
  input  logic [35:0]       peWdata,
  output logic [35:0]       peRdata,
  output logic              peBusy,
  output logic              clkStopReq,
  input  logic              clkStopAck,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [35:0]       memWdata,
  input  logic [35:0]       memRdata
);
  hmpStrobe_t strb;
  logic       wideLat, preLat, hostOwn;

  assign hostOwn = strb.own;

  hmpCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode),
    .hostReq(hostReq), .hostWe(hostWe), .hostWide(hostWide),
    .hostPreempt(hostPreempt), .hostBeat(hostBeat), .clkStopAck(clkStopAck),
    .strb(strb), .wideLat(wideLat), .preLat(preLat), .peBusy(peBusy),
    .clkStopReq(clkStopReq), .hostDone(hostDone)
  );

  hmpData #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wideLat(wideLat), .peBusy(peBusy),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRvalid(hostRvalid), .hostRdata(hostRdata),
    .peReq(peReq), .peWe(peWe), .peAddr(peAddr), .peWdata(peWdata),
    .peRdata(peRdata),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata)
  );
endmodule

// File: rtl/hmpChecker.sv
module hmpChecker (
  input logic clk,
  input logic rstN,
  input logic peBusy,
  input logic clkStopReq,
  input logic clkStopAck,
  input logic hostOwn,
  input logic preLat,
  input logic memEn,
  input logic hostRvalid,
  input logic hostDone
);
  p_stop_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostOwn && preLat) |-> clkStopReq);

  p_ack_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hostOwn) && preLat) |-> $past(clkStopAck));

  p_no_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (peBusy && !preLat) |-> !clkStopReq);

  p_pe_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (peBusy && !hostOwn) |-> !memEn);

  p_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    hostDone |=> !peBusy);

  p_beat_owned_r4: assert property (@(posedge clk) disable iff (!rstN)
    hostRvalid |-> (hostOwn && !hostDone));
endmodule

bind hostMemPort hmpChecker u_hmpChecker (
  .clk(clk), .rstN(rstN), .peBusy(peBusy), .clkStopReq(clkStopReq),
  .clkStopAck(clkStopAck), .hostOwn(hostOwn), .preLat(preLat),
  .memEn(memEn), .hostRvalid(hostRvalid), .hostDone(hostDone)
);

// File: tb/hostMemPort_bench.sv
module hostMemPort_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pipeMode = 1'b0;
  logic hostReq = 1'b0, hostWe = 1'b0, hostWide = 1'b0, hostPreempt = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic hostBeat = 1'b0;
  logic [31:0] hostWdata = '0;
  logic hostRvalid, hostDone;
  logic [31:0] hostRdata;
  logic peReq = 1'b0, peWe = 1'b0;
  logic [AW-1:0] peAddr = '0;
  logic [35:0] peWdata = '0;
  logic [35:0] peRdata;
  logic peBusy, clkStopReq;
  logic clkStopAck = 1'b0;
  logic memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [35:0] memWdata, memRdata;

  int checks = 0;
  int fails = 0;
  logic [35:0] mem [1024];
  logic [35:0] expMem [1024];
  logic [35:0] rd1 = '0, rd2 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostMemPort u_hostMemPort (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode),
    .hostReq(hostReq), .hostWe(hostWe), .hostWide(hostWide),
    .hostPreempt(hostPreempt), .hostAddr(hostAddr), .hostBeat(hostBeat),
    .hostWdata(hostWdata), .hostRvalid(hostRvalid), .hostRdata(hostRdata),
    .hostDone(hostDone), .peReq(peReq), .peWe(peWe), .peAddr(peAddr),
    .peWdata(peWdata), .peRdata(peRdata), .peBusy(peBusy),
    .clkStopReq(clkStopReq), .clkStopAck(clkStopAck),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  // Behavioural memory with selectable read latency
  always @(posedge clk) begin
    if (memEn && memWe) mem[memAddr] <= memWdata;
    if (memEn && !memWe) rd1 <= mem[memAddr];
    rd2 <= rd1;
  end
  assign memRdata = pipeMode ? rd2 : rd1;

  task automatic chkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    hostReq = 1'b0; hostBeat = 1'b0; peReq = 1'b0; peWe = 1'b0; clkStopAck = 1'b0;
  endtask

  task automatic hostAccess(input bit we, input bit wide, input bit pre, input int ackDelay,
                            input logic [AW-1:0] addr, input logic [31:0] lo,
                            input logic [31:0] hi, input logic [AW-1:0] peA,
                            input logic [35:0] peD);
    logic [35:0] word;
    int lat;
    // acceptance cycle, with a PE write in flight (R9)
    cyc();
    hostReq = 1'b1; hostWe = we; hostWide = wide; hostPreempt = pre; hostAddr = addr;
    peReq = 1'b1; peWe = 1'b1; peAddr = peA; peWdata = peD;
    #1;
    chkEq("R9 pe write forwarded at accept", {memEn, memWe, 22'(memAddr)}, {2'b11, 22'(peA)});
    chkEq("R9 pe word", 64'(memWdata), 64'(peD));
    chkEq("R10 not busy at accept", 64'(peBusy), 64'd0);
    expMem[peA] = peD;
    if (pre) begin
      for (int i = 0; i <= ackDelay; i++) begin
        cyc();
        clkStopAck = (i == ackDelay);
        peReq = 1'b1; peWe = 1'b1; peAddr = addr; peWdata = 36'hBAD;
        #1;
        chkEq("R7 stop requested", 64'(clkStopReq), 64'd1);
        chkEq("R7 R10 memory idle before ack", 64'(memEn), 64'd0);
        chkEq("R10 busy", 64'(peBusy), 64'd1);
      end
    end
    if (we) begin
      if (wide) begin
        cyc(); hostBeat = 1'b1; hostWdata = lo; #1;
        chkEq("R3 no write on first beat", 64'(memEn), 64'd0);
        chkEq("R7 R8 stop level", 64'(clkStopReq), 64'(pre));
        cyc(); peReq = 1'b1; peWe = 1'b1; #1;
        chkEq("R3 R10 no write in gap", 64'(memEn), 64'd0);
        cyc(); hostBeat = 1'b1; hostWdata = hi; #1;
        word = {hi[3:0], lo};
      end else begin
        cyc(); hostBeat = 1'b1; hostWdata = lo; #1;
        chkEq("R8 R7 stop level", 64'(clkStopReq), 64'(pre));
        word = {4'b0, lo};
      end
      chkEq(wide ? "R3 write strobe" : "R2 write strobe",
            {memEn, memWe, 22'(memAddr)}, {2'b11, 22'(addr)});
      chkEq(wide ? "R3 write word" : "R2 write word", 64'(memWdata), 64'(word));
      expMem[addr] = word;
    end else begin
      cyc(); #1;
      chkEq("R6 R8 read strobe", {memEn, memWe, 22'(memAddr)}, {2'b10, 22'(addr)});
      chkEq("R8 R7 stop level", 64'(clkStopReq), 64'(pre));
      lat = pipeMode ? 2 : 1;
      for (int i = 0; i < lat; i++) begin
        cyc(); #1;
        chkEq("R6 no beat during latency", 64'(hostRvalid), 64'd0);
      end
      cyc(); #1;
      chkEq("R4 R6 first beat valid", 64'(hostRvalid), 64'd1);
      chkEq("R4 low bits", 64'(hostRdata), 64'(expMem[addr][31:0]));
      if (wide) begin
        cyc(); #1;
        chkEq("R5 second beat valid", 64'(hostRvalid), 64'd1);
        chkEq("R5 high nibble", 64'(hostRdata), {60'd0, expMem[addr][35:32]});
      end
    end
    cyc(); #1;
    chkEq("R11 done pulse", 64'(hostDone), 64'd1);
    chkEq("R7 stop dropped at done", 64'(clkStopReq), 64'd0);
    chkEq("R10 busy at done", 64'(peBusy), 64'd1);
    chkEq("R11 no beat at done", 64'(hostRvalid), 64'd0);
    cyc();
    peReq = 1'b1; peWe = 1'b1; peAddr = peA + 1'b1; peWdata = peD ^ 36'h1;
    #1;
    chkEq("R11 released", {hostDone, peBusy, memEn}, 3'b001);
    expMem[peA + 1'b1] = peD ^ 36'h1;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = {4'(i + 9), 32'hA500_0000 | 32'(i)};
      expMem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    #1;
    chkEq("R1 reset outputs", {peBusy, clkStopReq, hostRvalid, hostDone, memEn}, 5'b0);
    rstN = 1'b1;
    cyc(); #1;
    chkEq("R1 idle after reset", {peBusy, clkStopReq, hostRvalid, hostDone}, 4'b0);

    pipeMode = 1'b0;
    hostAccess(1, 0, 0, 0, 10'd3,  32'h1234_5678, 32'h0, 10'd200, 36'hF_0000_0001);
    hostAccess(0, 1, 0, 0, 10'd3,  32'h0, 32'h0, 10'd210, 36'hE_0000_0002);
    hostAccess(1, 1, 1, 2, 10'd5,  32'hDEAD_BEEF, 32'h0000_000C, 10'd220, 36'hD_0000_0003);
    hostAccess(0, 1, 1, 0, 10'd5,  32'h0, 32'h0, 10'd230, 36'hC_0000_0004);
    hostAccess(0, 0, 0, 0, 10'd7,  32'h0, 32'h0, 10'd240, 36'hB_0000_0005);
    pipeMode = 1'b1;
    hostAccess(0, 1, 0, 0, 10'd5,  32'h0, 32'h0, 10'd250, 36'hA_0000_0006);
    hostAccess(0, 1, 1, 3, 10'd200, 32'h0, 32'h0, 10'd260, 36'h9_0000_0007);
    hostAccess(1, 0, 1, 1, 10'd5,  32'h0BAD_F00D, 32'h0, 10'd270, 36'h8_0000_0008);
    hostAccess(0, 1, 0, 0, 10'd5,  32'h0, 32'h0, 10'd280, 36'h7_0000_0009);
    hostAccess(0, 1, 0, 0, 10'd201, 32'h0, 32'h0, 10'd290, 36'h6_0000_000A);
    pipeMode = 1'b0;
    hostAccess(0, 1, 0, 0, 10'd221, 32'h0, 32'h0, 10'd300, 36'h5_0000_000B);
    finishRun();
  end
endmodule